// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Port

This block is a byte-wide real-time clock peripheral reached through two bus locations: an index location and a data location. A write to the index location latches a register number. A read of the data location then returns the register that number selects. The registers are the seconds, minutes, hours, weekday, day of month, month and year fields and a set of fixed control and status bytes. On reset the time fields are loaded in parallel from an initial-time input, and they then hold their values. The calendar does not advance.

A clock divider derives a 1024 Hz periodic tick from the system clock. On a tick the block latches an interrupt request, but only when no request is already pending. The request appears on `irq` and on bit 7 of a miscellaneous status byte. It stays there until an acknowledge input clears it. Some accesses have no meaning for this block: a write to the data location, a read of the fourth control register, and a read of an index with no register behind it. Each of these raises an error strobe in the same cycle as the access.

Top module: `rtc_index_port`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata` as the register index. A read with `bus_sel`=0 returns the stored index with no error. The index is 0 after reset.
- R2: A data read of index 0x0A returns {flag, 7'h26}, where flag is the update-in-progress bit. After reset the flag is 1, so the first read returns 0xA6.
- R3: The update-in-progress flag inverts after every data read of index 0x0A. Any other access leaves it unchanged.
- R4: A data read of index 0x0B returns 0x46. A data read of index 0x0C returns 0x00.
- R5: Data reads of indices 0x00, 0x02, 0x04, 0x06 and 0x07 return the seconds, minutes, hours, weekday and day-of-month values that were present on the initial-time inputs during reset.
- R6: Index 0x08 returns the stored zero-based month plus 1. Index 0x09 returns the stored year (years since 1900) minus 52, modulo 256.
- R7: The periodic tick occurs once every CLK_HZ/TICK_HZ clocks. The first tick falls in the cycle after the (DIV-1)th clock edge following reset release, and `irq` goes high at the DIV-th edge. A tick sets the pending latch only if it is clear.
- R8: Once set, `irq` and `misc_stat[7]` stay at 1 until a cycle with `irq_ack`=1. That cycle clears them at the next edge, unless a tick falls in the same cycle, in which case the tick wins and they stay at 1. The other `misc_stat` bits read 0.
- R9: `bus_err` is 1 in the same cycle as any of these accesses: a data write, a data read of index 0x0D, or a data read of any index not listed in R2, R4, R5 and R6. A data write changes no register. An erroring read returns 0x00.
- R10: During reset and directly after it, `irq`=0, `misc_stat`=0x00 and `bus_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the time fields |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | 0 selects the index location, 1 the data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| bus_err | output | 1 | Access error strobe |
| init_sec | input | 8 | Initial seconds |
| init_min | input | 8 | Initial minutes |
| init_hour | input | 8 | Initial hours |
| init_wday | input | 8 | Initial weekday |
| init_mday | input | 8 | Initial day of month |
| init_mon | input | 8 | Initial month, zero-based |
| init_year | input | 8 | Initial year, years since 1900 |
| irq_ack | input | 1 | Clears the pending periodic interrupt |
| irq | output | 1 | Pending periodic interrupt |
| misc_stat | output | 8 | Status byte; bit 7 mirrors the pending interrupt |

## Verification
The periodic tick and the acknowledge can fall in the same cycle, and then the tick must win so that no interrupt is lost. The bench tracks the tick phase by counting edges from reset release. It asserts `irq_ack` exactly in the tick cycle and expects `irq` to stay high. It then acknowledges in a cycle away from the tick and expects `irq` to fall. The other collision is a read of index 0x0A in the same cycle as a tick. The bench judges this by checking that the flag sequence and the interrupt timing each stay intact while the full index sweep runs alongside the ticks.

// File: rtl/rtc_index_port.sv
module rtc_index_port #(
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 1024,
  parameter int YEAR_OFS = 52
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_err,
  input  logic [7:0] init_sec,
  input  logic [7:0] init_min,
  input  logic [7:0] init_hour,
  input  logic [7:0] init_wday,
  input  logic [7:0] init_mday,
  input  logic [7:0] init_mon,
  input  logic [7:0] init_year,
  input  logic       irq_ack,
  output logic       irq,
  output logic [7:0] misc_stat
);
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [7:0] YOFS = 8'(YEAR_OFS);

  logic [7:0] idx;
  logic       uip;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year;
  logic [CW-1:0] div_cnt;
  logic       tick;
  logic       pend;
  logic [7:0] data_val;
  logic       data_bad;

  wire data_rd = bus_rd && bus_sel;
  wire data_wr = bus_wr && bus_sel;
  wire rd_ctl_a = data_rd && (idx == 8'h0A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= 8'h00;
      t_sec  <= init_sec;
      t_min  <= init_min;
      t_hour <= init_hour;
      t_wday <= init_wday;
      t_mday <= init_mday;
      t_mon  <= init_mon;
      t_year <= init_year;
    end else if (bus_wr && !bus_sel) begin
      idx <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        uip <= 1'b1;
    else if (rd_ctl_a) uip <= ~uip;
  end

  assign tick = (div_cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (tick)    pend <= 1'b1;
    else if (irq_ack) pend <= 1'b0;
  end

  always_comb begin
    data_bad = 1'b0;
    case (idx)
      8'h00:   data_val = t_sec;
      8'h02:   data_val = t_min;
      8'h04:   data_val = t_hour;
      8'h06:   data_val = t_wday;
      8'h07:   data_val = t_mday;
      8'h08:   data_val = t_mon + 8'd1;
      8'h09:   data_val = t_year - YOFS;
      8'h0A:   data_val = {uip, 7'h26};
      8'h0B:   data_val = 8'h46;
      8'h0C:   data_val = 8'h00;
      default: begin
        data_val = 8'h00;
        data_bad = 1'b1;
      end
    endcase
  end

  assign bus_rdata = !bus_rd ? 8'h00 : (bus_sel ? data_val : idx);
  assign bus_err   = data_wr || (data_rd && data_bad);
  assign irq       = pend;
  assign misc_stat = {pend, 7'b0};
endmodule

module rtc_index_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_sel,
  input logic [7:0] bus_wdata,
  input logic [7:0] idx,
  input logic       uip,
  input logic       tick,
  input logic       irq,
  input logic       irq_ack,
  input logic       bus_err
);
  a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> (idx == $past(bus_wdata)));
  a_r3_flag_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel && idx == 8'h0A) |=> (uip != $past(uip)));
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_sel && idx == 8'h0A) |=> $stable(uip));
  a_r7_raise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !irq) |=> !irq);
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  a_r9_data_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel) |-> bus_err);
endmodule

bind rtc_index_port rtc_index_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .idx(idx), .uip(uip), .tick(tick), .irq(irq),
  .irq_ack(irq_ack), .bus_err(bus_err)
);

// File: tb/test_rtc_index_port.sv
module test_rtc_index_port;
  localparam int DIV = 16;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, bus_sel = 0, irq_ack = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, misc_stat;
  logic bus_err, irq;
  logic [7:0] i_sec = 8'd37, i_min = 8'd12, i_hour = 8'd23, i_wday = 8'd4;
  logic [7:0] i_mday = 8'd31, i_mon = 8'd11, i_year = 8'd106;
  int checks = 0, errors = 0;
  int ecount = 0;

  always #2.5 clk = ~clk;

  rtc_index_port #(.CLK_HZ(DIV * 1024), .TICK_HZ(1024)) i_rtc_index_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .init_sec(i_sec), .init_min(i_min), .init_hour(i_hour), .init_wday(i_wday),
    .init_mday(i_mday), .init_mon(i_mon), .init_year(i_year),
    .irq_ack(irq_ack), .irq(irq), .misc_stat(misc_stat));

  always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 irq in reset", irq, 0);
    chk("R10 misc in reset", misc_stat, 0);
    rst_n = 1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] v, output logic e);
    @(negedge clk);
    bus_wr = 1; bus_sel = sel; bus_wdata = v;
    #1 e = bus_err;
    @(negedge clk) bus_wr = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v, output logic e);
    @(negedge clk);
    bus_rd = 1; bus_sel = sel;
    #1 v = bus_rdata; e = bus_err;
    @(negedge clk) bus_rd = 0;
  endtask

  function automatic int expect_val(input int ix, input logic f, output logic bad);
    bad = 0;
    case (ix)
      0: return i_sec;
      2: return i_min;
      4: return i_hour;
      6: return i_wday;
      7: return i_mday;
      8: return (i_mon + 1) % 256;
      9: return (i_year + 256 - 52) % 256;
      10: return f * 128 + 'h26;
      11: return 'h46;
      12: return 0;
      default: begin bad = 1; return 0; end
    endcase
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v; logic e, bad, flag; int n, exp;
    do_reset();
    n = 0;
    while (irq !== 1 && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    chk("R7 first tick edges", n, DIV);
    chk("R8 misc bit7", misc_stat, 8'h80);
    rd(0, v, e);
    chk("R1 index reset 0", v, 0);
    chk("R10 no err", e, 0);

    flag = 1;
    for (int ix = 0; ix < 256; ix++) begin
      wr(0, ix[7:0], e);
      rd(0, v, e);
      chk("R1 index readback", v, ix);
      rd(1, v, e);
      exp = expect_val(ix, flag, bad);
      chk($sformatf("R2 R4 R5 R6 R9 value idx %0h", ix), v, exp);
      chk($sformatf("R9 err idx %0h", ix), e, bad);
      if (ix == 10) flag = ~flag;
    end
    chk("R8 irq held without ack", irq, 1);

    wr(0, 8'h0A, e);
    for (int k = 0; k < 4; k++) begin
      rd(1, v, e);
      chk("R2 R3 flag toggles", v, flag * 128 + 'h26);
      flag = ~flag;
    end
    wr(0, 8'h0B, e);
    rd(1, v, e);
    wr(0, 8'h0A, e);
    rd(1, v, e);
    chk("R3 other reads keep flag", v, flag * 128 + 'h26);
    flag = ~flag;

    wr(0, 8'h00, e);
    wr(1, 8'h55, e);
    chk("R9 data write err", e, 1);
    rd(1, v, e);
    chk("R9 data write no effect", v, i_sec);

    while ((ecount % DIV) != DIV - 1) @(negedge clk);
    irq_ack = 1;
    @(negedge clk) irq_ack = 0;
    chk("R8 tick beats ack", irq, 1);
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
    chk("R8 ack clears irq", irq, 0);
    chk("R8 ack clears misc", misc_stat, 0);
    n = ecount % DIV;
    while (irq !== 1) @(negedge clk);
    chk("R7 raise phase", ecount % DIV, 0);

    i_year = 8'd40; i_mon = 8'd0;
    do_reset();
    @(negedge clk);
    chk("R10 irq after reset", irq, 0);
    wr(0, 8'h09, e);
    rd(1, v, e);
    chk("R6 year wrap", v, 8'hF4);
    wr(0, 8'h08, e);
    rd(1, v, e);
    chk("R6 month from 1", v, 1);
    wr(0, 8'h0A, e);
    rd(1, v, e);
    chk("R2 flag 1 after reset", v, 8'hA6);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule